// File: doc/BRIEF.md
# Light-Load Conduction Mode Selector

This block sits beside the modulator of a synchronous buck converter and picks, once per switching period, between forced continuous conduction (the low-side switch may carry current in both directions) and diode emulation (the low-side switch is opened as soon as inductor current turns negative). A period is the span from one high-side pulse strobe up to the next. During each period the block records two facts about the low-side on time: whether the low-side gate was on, and whether the zero-cross comparator flagged reverse current while it was on.

Emulation is entered only after a run of consecutive periods that all show reverse current. It is left at the first strobe that closes a period in which the low side conducted with no reverse current seen. While emulation is active, the block asks the modulator to widen its hysteretic window. The wider window lowers the switching frequency and stops the mode from chattering at the conduction boundary. It also gates the low-side drive off from the clock where reverse current appears until the next high-side pulse. Until soft-start has finished, the block holds the converter in forced continuous conduction.

Top module: `dem_mode_ctrl`

## Requirements
- R1: With soft-start done, `dem_active` rises in the cycle after the strobe that closes the ENTRY_CYCLES-th consecutive period (default 8) in which `rev_cur` was high at some clock while `ls_on` was high. A period runs from a `pwm_strobe` clock, inclusive, up to the next strobe, exclusive.
- R2: A period whose low-side on time shows no reverse current clears the run of reverse periods. After such a break, a full new run of ENTRY_CYCLES periods is needed before entry.
- R3: `rev_cur` is ignored at every clock where `ls_on` is low. Reverse current seen only outside the low-side on time never counts toward entry.
- R4: While in emulation, `dem_active` falls in the cycle after the strobe that closes a period in which `ls_on` was high and reverse current was never seen. A period with no low-side on time at all does not cause an exit.
- R5: `win_wide` is 1 exactly when emulation is active, and 0 (nominal window) in forced continuous conduction.
- R6: While `ss_done` is low, emulation is off and the run of reverse periods is held at zero. This also applies when soft-start drops at the very strobe that would otherwise have entered emulation.
- R7: In emulation, `ls_en` goes low combinationally in the same clock where `ls_on` and `rev_cur` are both high. It stays low for the rest of that period and returns to 1 at the next `pwm_strobe`.
- R8: Outside emulation, `ls_en` is 1 regardless of `rev_cur` and `ls_on`.
- R9: Synchronous active-high `rst` clears the emulation state, the reverse-period run, the held gate block and `win_wide`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous reset, active high |
| pwm_strobe | input | 1 | One-clock pulse at the start of each high-side pulse |
| ls_on | input | 1 | Low-side gate is currently on |
| rev_cur | input | 1 | Zero-cross comparator: reverse current through the low-side switch |
| ss_done | input | 1 | Soft-start has completed |
| dem_active | output | 1 | Diode emulation is active |
| ls_en | output | 1 | Low-side gate permission, 0 blocks the low side |
| win_wide | output | 1 | Selects the widened hysteretic window |

## Verification
The clash that matters most is the strobe that closes the eighth reverse period arriving together with a loss of soft-start. At that one edge, the entry decision and the forced return to continuous conduction compete. The bench builds seven reverse periods, lowers `ss_done` right at the eighth period's closing strobe, and expects `dem_active` to stay low and the run to start again from zero. A second overlap is the strobe that both re-arms the low-side gate and decides on exit. This is judged by checking `ls_en` and `dem_active` together in the first clock of the new period.

// File: rtl/dem_ctrl_pkg.sv
package dem_ctrl_pkg;
   typedef struct packed {
      logic lo_seen;
      logic rev_seen;
   } period_sum_t;

   typedef enum logic {
      MODE_CCM = 1'b0,
      MODE_DEM = 1'b1
   } cond_mode_e;
endpackage

// File: rtl/dem_period_monitor.sv
module dem_period_monitor
   import dem_ctrl_pkg::*;
(
   input  logic        clk,
   input  logic        rst,
   input  logic        strobe,
   input  logic        ls_on,
   input  logic        rev_cur,
   output period_sum_t closed_sum
);
   period_sum_t acc_q;
   logic        rev_gated;

   // reverse current only counts during the low-side on time
   assign rev_gated = ls_on & rev_cur;

   always_ff @(posedge clk) begin
      if (rst) begin
         acc_q <= '0;
      end else if (strobe) begin
         acc_q.lo_seen  <= ls_on;
         acc_q.rev_seen <= rev_gated;
      end else begin
         acc_q.lo_seen  <= acc_q.lo_seen | ls_on;
         acc_q.rev_seen <= acc_q.rev_seen | rev_gated;
      end
   end

   // summary of the period that the current strobe closes
   assign closed_sum = acc_q;
endmodule

// File: rtl/dem_run_counter.sv
module dem_run_counter #(
   parameter int unsigned RUN_LEN = 8
) (
   input  logic clk,
   input  logic rst,
   input  logic strobe,
   input  logic allow,
   input  logic rev_seen,
   output logic run_done
);
   localparam int unsigned CW = $clog2(RUN_LEN + 1);
   localparam logic [CW-1:0] LAST = CW'(RUN_LEN - 1);
   localparam logic [CW-1:0] FULL = CW'(RUN_LEN);

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (rst || !allow) begin
         cnt_q <= '0;
      end else if (strobe) begin
         if (!rev_seen)
            cnt_q <= '0;
         else if (cnt_q != FULL)
            cnt_q <= cnt_q + 1'b1;
      end
   end

   assign run_done = strobe && allow && rev_seen && (cnt_q >= LAST);
endmodule

// File: rtl/dem_mode_fsm.sv
module dem_mode_fsm
   import dem_ctrl_pkg::*;
(
   input  logic        clk,
   input  logic        rst,
   input  logic        strobe,
   input  logic        allow,
   input  logic        run_done,
   input  period_sum_t closed_sum,
   output logic        in_dem
);
   cond_mode_e mode_q;
   logic       leave;

   assign leave = strobe && closed_sum.lo_seen && !closed_sum.rev_seen;

   always_ff @(posedge clk) begin
      if (rst || !allow) begin
         mode_q <= MODE_CCM;
      end else begin
         unique case (mode_q)
            MODE_CCM: if (run_done) mode_q <= MODE_DEM;
            MODE_DEM: if (leave)    mode_q <= MODE_CCM;
            default:                mode_q <= MODE_CCM;
         endcase
      end
   end

   assign in_dem = (mode_q == MODE_DEM);
endmodule

// File: rtl/dem_gate_blank.sv
module dem_gate_blank #(
   parameter bit HOLD_TO_PULSE = 1'b1
) (
   input  logic clk,
   input  logic rst,
   input  logic strobe,
   input  logic in_dem,
   input  logic ls_on,
   input  logic rev_cur,
   output logic ls_en
);
   logic rev_now;
   assign rev_now = in_dem & ls_on & rev_cur;

   generate
      if (HOLD_TO_PULSE) begin : g_hold
         logic blk_q;
         always_ff @(posedge clk) begin
            if (rst || strobe || !in_dem)
               blk_q <= 1'b0;
            else if (rev_now)
               blk_q <= 1'b1;
         end
         assign ls_en = !(rev_now || (in_dem && blk_q));
      end else begin : g_direct
         assign ls_en = !rev_now;
      end
   endgenerate
endmodule

// File: rtl/dem_mode_ctrl.sv
module dem_mode_ctrl
   import dem_ctrl_pkg::*;
#(
   parameter int unsigned ENTRY_CYCLES  = 8,
   parameter bit          HOLD_TO_PULSE = 1'b1
) (
   input  logic clk,
   input  logic rst,
   input  logic pwm_strobe,
   input  logic ls_on,
   input  logic rev_cur,
   input  logic ss_done,
   output logic dem_active,
   output logic ls_en,
   output logic win_wide
);
   generate
      if (ENTRY_CYCLES < 2) begin : g_bad_len
         $error("ENTRY_CYCLES must be at least 2");
      end
   endgenerate

   period_sum_t sum_w;
   logic        run_done_w;
   logic        in_dem_w;

   dem_period_monitor u_mon (
      .clk        (clk),
      .rst        (rst),
      .strobe     (pwm_strobe),
      .ls_on      (ls_on),
      .rev_cur    (rev_cur),
      .closed_sum (sum_w)
   );

   dem_run_counter #(.RUN_LEN(ENTRY_CYCLES)) u_run (
      .clk      (clk),
      .rst      (rst),
      .strobe   (pwm_strobe),
      .allow    (ss_done),
      .rev_seen (sum_w.rev_seen),
      .run_done (run_done_w)
   );

   dem_mode_fsm u_fsm (
      .clk        (clk),
      .rst        (rst),
      .strobe     (pwm_strobe),
      .allow      (ss_done),
      .run_done   (run_done_w),
      .closed_sum (sum_w),
      .in_dem     (in_dem_w)
   );

   dem_gate_blank #(.HOLD_TO_PULSE(HOLD_TO_PULSE)) u_gate (
      .clk     (clk),
      .rst     (rst),
      .strobe  (pwm_strobe),
      .in_dem  (in_dem_w),
      .ls_on   (ls_on),
      .rev_cur (rev_cur),
      .ls_en   (ls_en)
   );

   assign dem_active = in_dem_w;
   assign win_wide   = in_dem_w;
endmodule

// File: rtl/dem_mode_ctrl_chk.sv
module dem_mode_ctrl_chk (
   input logic clk,
   input logic rst,
   input logic pwm_strobe,
   input logic ls_on,
   input logic rev_cur,
   input logic ss_done,
   input logic dem_active,
   input logic ls_en,
   input logic win_wide
);
   assert_entry_on_strobe_R1: assert property (@(posedge clk) disable iff (rst)
      $rose(dem_active) |-> ($past(pwm_strobe) && $past(ss_done)));

   assert_exit_on_strobe_R4: assert property (@(posedge clk) disable iff (rst)
      $fell(dem_active) |-> ($past(pwm_strobe) || !$past(ss_done)));

   assert_window_follows_R5: assert property (@(posedge clk) disable iff (rst)
      win_wide == dem_active);

   assert_ccm_in_softstart_R6: assert property (@(posedge clk) disable iff (rst)
      !ss_done |=> !dem_active);

   assert_block_on_reverse_R7: assert property (@(posedge clk) disable iff (rst)
      (dem_active && ls_on && rev_cur) |-> !ls_en);

   assert_no_block_in_ccm_R8: assert property (@(posedge clk) disable iff (rst)
      !dem_active |-> ls_en);

   assert_reset_clears_R9: assert property (@(posedge clk)
      rst |=> (!dem_active && !win_wide));
endmodule

bind dem_mode_ctrl dem_mode_ctrl_chk u_chk (.*);

// File: tb/dem_mode_ctrl_tb_top.sv
module dem_mode_ctrl_tb_top;
   localparam int N = 8;

   logic clk = 1'b0;
   logic rst, pwm_strobe, ls_on, rev_cur, ss_done;
   logic dem_active, ls_en, win_wide;

   int checks = 0;
   int errors = 0;

   // reference model state
   bit m_ls, m_rev, m_dem;
   int m_cnt;

   always #2 clk = ~clk;

   dem_mode_ctrl dut_i (
      .clk(clk), .rst(rst), .pwm_strobe(pwm_strobe), .ls_on(ls_on),
      .rev_cur(rev_cur), .ss_done(ss_done), .dem_active(dem_active),
      .ls_en(ls_en), .win_wide(win_wide)
   );

   task automatic check(input string req, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1; pwm_strobe = 1'b0; ls_on = 1'b0; rev_cur = 1'b0;
      @(negedge clk);
      @(negedge clk);
      rst = 1'b0;
      m_ls = 0; m_rev = 0; m_dem = 0; m_cnt = 0;
   endtask

   // one switching period: strobe clock, then low-side on time, then idle
   task automatic period(input bit has_ls, input bit rev, input bit rev_off, input string req);
      @(negedge clk);
      pwm_strobe = 1'b1; ls_on = 1'b0; rev_cur = rev_off;
      if (!ss_done) begin
         m_cnt = 0; m_dem = 0;
      end else begin
         if (m_rev) m_cnt = (m_cnt < N) ? m_cnt + 1 : N;
         else       m_cnt = 0;
         if (!m_dem && m_rev && m_cnt >= N) m_dem = 1;
         else if (m_dem && m_ls && !m_rev) m_dem = 0;
      end
      m_ls = 0; m_rev = 0;
      @(negedge clk);
      pwm_strobe = 1'b0; rev_cur = 1'b0;
      #1;
      check(req, dem_active, m_dem);
      check("R5", win_wide, m_dem);
      check(m_dem ? "R7" : "R8", ls_en, 1'b1);
      ls_on = has_ls;
      @(negedge clk);
      rev_cur = rev;
      #1;
      check(m_dem ? "R7" : "R8", ls_en, !(m_dem && has_ls && rev));
      if (has_ls) m_ls = 1;
      if (has_ls && rev) m_rev = 1;
      @(negedge clk);
      rev_cur = 1'b0;
      #1;
      check(m_dem ? "R7" : "R8", ls_en, !(m_dem && has_ls && rev));
      @(negedge clk);
      ls_on = 1'b0; rev_cur = rev_off;
      #1;
      check("R8", ls_en, !(m_dem && has_ls && rev));
   endtask

   initial begin
      #400000;
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      ss_done = 1'b1;
      do_reset();
      #1;
      check("R9", dem_active, 1'b0);
      check("R9", win_wide, 1'b0);
      check("R9", ls_en, 1'b1);

      // R6: soft-start not done, reverse current every period
      ss_done = 1'b0;
      for (int i = 0; i < 10; i++) period(1, 1, 0, "R6");
      ss_done = 1'b1;

      // R1/R2/R4 sweep of run lengths
      for (int k = 1; k <= 10; k++) begin
         do_reset();
         period(0, 0, 0, "R1");
         for (int i = 0; i < k; i++) period(1, 1, 0, "R1");
         period(1, 0, 0, "R1");
         period(1, 0, 0, "R4");
         check("R4", dem_active, 1'b0);
      end

      // R2: seven reverse, a break, then one reverse: no entry
      do_reset();
      for (int i = 0; i < 7; i++) period(1, 1, 0, "R2");
      period(1, 0, 0, "R2");
      for (int i = 0; i < 7; i++) period(1, 1, 0, "R2");
      period(1, 0, 0, "R2");
      check("R2", dem_active, 1'b0);

      // R3: reverse flagged only while low side is off
      do_reset();
      for (int i = 0; i < 10; i++) period(1, 0, 1, "R3");
      period(1, 0, 0, "R3");
      check("R3", dem_active, 1'b0);

      // R4: enter, a period without low side keeps emulation, forward exits
      do_reset();
      for (int i = 0; i < 8; i++) period(1, 1, 0, "R1");
      period(1, 1, 0, "R1");
      check("R1", dem_active, 1'b1);
      period(0, 0, 0, "R4");
      period(1, 1, 0, "R4");
      check("R4", dem_active, 1'b1);
      period(1, 0, 0, "R4");
      period(1, 0, 0, "R4");
      check("R4", dem_active, 1'b0);

      // R6: soft-start drops at the eighth period's closing strobe
      do_reset();
      for (int i = 0; i < 8; i++) period(1, 1, 0, "R6");
      ss_done = 1'b0;
      period(1, 1, 0, "R6");
      check("R6", dem_active, 1'b0);
      ss_done = 1'b1;
      for (int i = 0; i < 7; i++) period(1, 1, 0, "R6");
      check("R6", dem_active, 1'b0);

      // R9: reset while in emulation
      do_reset();
      for (int i = 0; i < 9; i++) period(1, 1, 0, "R1");
      check("R1", dem_active, 1'b1);
      do_reset();
      #1;
      check("R9", dem_active, 1'b0);
      check("R9", win_wide, 1'b0);
      check("R9", ls_en, 1'b1);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule